// File: doc/BRIEF.md
# Segment Offset Bound Checker

This block decides whether a memory access made through a loaded segment descriptor falls inside the segment. Each descriptor carries a base address, a 20-bit raw limit, a granularity flag, a big flag and an expand-down flag. Each request carries an offset, an access size of 1, 2 or 4 bytes, and a tag that marks it as a stack access. The block expands the raw limit into an effective limit. It checks both the first byte and the last byte of the access against the valid offset range. It also forms the linear address as base plus offset.

The checker sits between address generation and the memory pipeline. A violation is reported as a stack fault when the request carries the stack tag, and as a general-protection fault otherwise. The result is registered, so it appears one cycle after the request. Expand-down segments invert the valid range. For them, the effective limit names the highest offset that cannot be accessed, and the upper end of the range depends on the big flag.

Top module: `seg_bound_check`

## Requirements
- R1: With the granularity flag at 0, the effective limit equals the 20-bit raw limit, zero-extended to 32 bits.
- R2: With the granularity flag at 1, the effective limit is the raw limit shifted left by 12 with ones in the low 12 bits. A raw value of 0 therefore yields 0000_0FFFh.
- R3: For an expand-up segment, an access is valid only when its last byte offset (offset + size − 1) is at or below the effective limit.
- R4: For an expand-down segment, an access is valid only when its first offset is strictly above the effective limit and its last byte is at or below the upper bound. The upper bound is 0000_FFFFh when big = 0 and FFFF_FFFFh when big = 1. With big = 1, granularity 1 and raw limit F_FFFFh, every access faults.
- R5: The size code `acc_size` selects the byte count: 2'b00 is 1 byte, 2'b01 is 2 bytes, and 2'b10 or 2'b11 is 4 bytes.
- R6: An access whose last byte would carry past FFFF_FFFFh is a violation for either segment direction.
- R7: `rsp_lin` equals base plus offset, modulo 2^32.
- R8: A violation on a request with `acc_stack` = 1 raises only `rsp_stk_flt`. Any other violation raises only `rsp_gp_flt`. The two are never high together.
- R9: A request with `req_vld` = 1 produces `rsp_vld` = 1 and its flags on the next cycle. When no request was presented, `rsp_vld` and both fault flags are 0 on the next cycle.
- R10: While `rst` is high, all outputs are zero after the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Request present this cycle |
| dsc_base | input | 32 | Segment base address |
| dsc_lim | input | 20 | Raw limit field |
| dsc_gran | input | 1 | 1 = limit counted in 4 KiB pages |
| dsc_big | input | 1 | Expand-down upper bound select (1 = 32-bit) |
| dsc_down | input | 1 | 1 = expand-down segment |
| acc_off | input | 32 | Segment-relative offset |
| acc_size | input | 2 | Access size code |
| acc_stack | input | 1 | Request is a stack access |
| rsp_vld | output | 1 | Registered result valid |
| rsp_lin | output | 32 | Linear address |
| rsp_gp_flt | output | 1 | General-protection fault |
| rsp_stk_flt | output | 1 | Stack fault |

## Verification
The sweep places offsets on both sides of each effective limit, at the 64 KiB boundary and at the top of the 32-bit space. It crosses these offsets with every size code and every descriptor flag combination. An off-by-one in the inclusive or exclusive limit shows up as a fault missing, or a fault raised, exactly at the limit. Checking only the first byte would let multi-byte accesses that straddle the limit or wrap past FFFF_FFFFh through. Ignoring the big flag would accept expand-down offsets above FFFFh. Directed vectors cover the all-faulting expand-down page descriptor and the raw-zero page limit of 0FFFh.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;

    localparam int ADDR_W  = 32;
    localparam int LIM_W   = 20;
    localparam int PAGE_SH = ADDR_W - LIM_W;
    localparam int SMALL_W = 16;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [LIM_W-1:0]  lim;
        logic              gran;
        logic              big;
        logic              down;
    } seg_desc_t;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WIDE = 2'b11
    } acc_size_e;

    typedef struct packed {
        logic [ADDR_W-1:0] off;
        acc_size_e         size;
        logic              stack;
    } seg_acc_t;

    // number of extra bytes beyond the first one
    function automatic logic [2:0] size_extra(acc_size_e s);
        case (s)
            SZ_BYTE: size_extra = 3'd0;
            SZ_HALF: size_extra = 3'd1;
            default: size_extra = 3'd3;
        endcase
    endfunction

endpackage

// File: rtl/seg_lim_expand.sv
module seg_lim_expand
    import seg_chk_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int LW = LIM_W
) (
    input  logic [LW-1:0] raw_lim,
    input  logic          gran,
    output logic [AW-1:0] eff_lim
);
    localparam int SH = AW - LW;

    logic [AW-1:0] byte_lim;
    logic [AW-1:0] page_lim;

    generate
        if (SH > 0) begin : g_shift
            assign byte_lim = {{SH{1'b0}}, raw_lim};
            assign page_lim = {raw_lim, {SH{1'b1}}};
        end else begin : g_flat
            assign byte_lim = raw_lim[AW-1:0];
            assign page_lim = raw_lim[AW-1:0];
        end
    endgenerate

    assign eff_lim = gran ? page_lim : byte_lim;

endmodule

// File: rtl/seg_range_check.sv
module seg_range_check
    import seg_chk_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int SW = SMALL_W
) (
    input  logic [AW-1:0] eff_lim,
    input  logic          big,
    input  logic          down,
    input  logic [AW-1:0] off,
    input  acc_size_e     size,
    output logic          in_range
);
    logic [AW:0]   last_ext;
    logic          carry;
    logic [AW-1:0] last;
    logic [AW-1:0] upper;
    logic          up_ok;
    logic          dn_ok;

    always_comb begin
        last_ext = {1'b0, off} + {{(AW-2){1'b0}}, size_extra(size)};
        carry    = last_ext[AW];
        last     = last_ext[AW-1:0];
        upper    = big ? {AW{1'b1}} : {{(AW-SW){1'b0}}, {SW{1'b1}}};
        up_ok    = !carry && (last <= eff_lim);
        dn_ok    = !carry && (off > eff_lim) && (last <= upper);
        in_range = down ? dn_ok : up_ok;
    end

endmodule

// File: rtl/seg_lin_addr.sv
module seg_lin_addr
    import seg_chk_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] off,
    output logic [AW-1:0] lin
);
    assign lin = base + off;
endmodule

// File: rtl/seg_bound_check.sv
module seg_bound_check
    import seg_chk_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int LW = LIM_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_vld,
    input  logic [AW-1:0] dsc_base,
    input  logic [LW-1:0] dsc_lim,
    input  logic          dsc_gran,
    input  logic          dsc_big,
    input  logic          dsc_down,
    input  logic [AW-1:0] acc_off,
    input  logic [1:0]    acc_size,
    input  logic          acc_stack,
    output logic          rsp_vld,
    output logic [AW-1:0] rsp_lin,
    output logic          rsp_gp_flt,
    output logic          rsp_stk_flt
);
    seg_desc_t     desc;
    seg_acc_t      acc;
    logic [AW-1:0] eff_lim;
    logic          in_range;
    logic [AW-1:0] lin_d;

    assign desc = '{base: dsc_base, lim: dsc_lim, gran: dsc_gran,
                    big: dsc_big, down: dsc_down};
    assign acc  = '{off: acc_off, size: acc_size_e'(acc_size), stack: acc_stack};

    seg_lim_expand #(.AW(AW), .LW(LW)) u_expand (
        .raw_lim (desc.lim),
        .gran    (desc.gran),
        .eff_lim (eff_lim)
    );

    seg_range_check #(.AW(AW), .SW(SMALL_W)) u_range (
        .eff_lim  (eff_lim),
        .big      (desc.big),
        .down     (desc.down),
        .off      (acc.off),
        .size     (acc.size),
        .in_range (in_range)
    );

    seg_lin_addr #(.AW(AW)) u_lin (
        .base (desc.base),
        .off  (acc.off),
        .lin  (lin_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_vld     <= 1'b0;
            rsp_lin     <= '0;
            rsp_gp_flt  <= 1'b0;
            rsp_stk_flt <= 1'b0;
        end else begin
            rsp_vld     <= req_vld;
            rsp_lin     <= lin_d;
            rsp_gp_flt  <= req_vld && !in_range && !acc.stack;
            rsp_stk_flt <= req_vld && !in_range && acc.stack;
        end
    end

    p_one_fault_r8: assert property (@(posedge clk) disable iff (rst)
        !(rsp_gp_flt && rsp_stk_flt));

    p_stack_route_r8: assert property (@(posedge clk) disable iff (rst)
        (req_vld && acc_stack) |=> !rsp_gp_flt);

    p_latency_r9: assert property (@(posedge clk) disable iff (rst)
        req_vld |=> rsp_vld);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !req_vld |=> (!rsp_vld && !rsp_gp_flt && !rsp_stk_flt));

    p_lin_sum_r7: assert property (@(posedge clk) disable iff (rst)
        req_vld |=> (rsp_lin == $past(dsc_base) + $past(acc_off)));

    p_nofault_page_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (req_vld && !dsc_down && dsc_gran && dsc_lim == '0 &&
         acc_size == 2'b00 && acc_off < AW'(4096)) |=> (!rsp_gp_flt && !rsp_stk_flt));

endmodule

// File: tb/seg_bound_check_bench.sv
module seg_bound_check_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_vld;
    logic [31:0] dsc_base;
    logic [19:0] dsc_lim;
    logic        dsc_gran, dsc_big, dsc_down;
    logic [31:0] acc_off;
    logic [1:0]  acc_size;
    logic        acc_stack;
    logic        rsp_vld;
    logic [31:0] rsp_lin;
    logic        rsp_gp_flt, rsp_stk_flt;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    seg_bound_check u_seg_bound_check (
        .clk, .rst, .req_vld, .dsc_base, .dsc_lim, .dsc_gran, .dsc_big,
        .dsc_down, .acc_off, .acc_size, .acc_stack, .rsp_vld, .rsp_lin,
        .rsp_gp_flt, .rsp_stk_flt
    );

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // independent reference from the requirements
    function automatic bit ref_ok(logic [19:0] lim, bit gran, bit big, bit down,
                                  logic [31:0] off, logic [1:0] sz);
        longint elim, last, upper, n;
        elim  = gran ? (longint'(lim) * 4096 + 4095) : longint'(lim);   // R1 R2
        n     = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;               // R5
        last  = longint'(off) + n - 1;
        upper = big ? 64'hFFFF_FFFF : 64'hFFFF;
        if (last > 64'hFFFF_FFFF) return 0;                             // R6
        if (down) return (longint'(off) > elim) && (last <= upper);      // R4
        return last <= elim;                                             // R3
    endfunction

    task automatic apply(input logic [31:0] base, input logic [19:0] lim, input bit gran,
                         input bit big, input bit down, input logic [31:0] off,
                         input logic [1:0] sz, input bit stk);
        bit ok;
        string tag;
        @(negedge clk);
        req_vld = 1; dsc_base = base; dsc_lim = lim; dsc_gran = gran;
        dsc_big = big; dsc_down = down; acc_off = off; acc_size = sz; acc_stack = stk;
        @(posedge clk);
        #1;
        ok  = ref_ok(lim, gran, big, down, off, sz);
        tag = down ? "R4" : (gran ? "R2" : "R1");
        if (sz != 2'b00) tag = {tag, " R5"};
        chk({63'd0, rsp_vld}, 64'd1, "R9 valid");
        chk({63'd0, rsp_gp_flt}, {63'd0, !ok && !stk}, {tag, " R3 R6 gp"});
        chk({63'd0, rsp_stk_flt}, {63'd0, !ok && stk}, {tag, " R8 stack"});
        chk({32'd0, rsp_lin}, {32'd0, base + off}, "R7 linear");
    endtask

    function automatic logic [31:0] pick_off(int k, logic [31:0] elim);
        if (k < 4)  return 32'(k);
        if (k < 11) return elim - 32'd3 + 32'(k - 4);
        if (k < 15) return 32'h0000_FFFC + 32'(k - 11);
        if (k < 18) return 32'h0001_0000 + 32'(k - 15);
        if (k < 22) return 32'hFFFF_FFFC + 32'(k - 18);
        if (k == 22) return 32'h0000_1000;
        return 32'h8000_0000;
    endfunction

    initial begin
        logic [19:0] lims [6];
        lims = '{20'h0, 20'h1, 20'h007FF, 20'h0FC00, 20'h0FFFF, 20'hFFFFF};
        rst = 1; req_vld = 0; dsc_base = 0; dsc_lim = 0; dsc_gran = 0;
        dsc_big = 0; dsc_down = 0; acc_off = 0; acc_size = 0; acc_stack = 0;
        repeat (3) @(posedge clk);
        #1;
        chk({61'd0, rsp_vld, rsp_gp_flt, rsp_stk_flt}, 64'd0, "R10 flags");
        chk({32'd0, rsp_lin}, 64'd0, "R10 lin");
        @(negedge clk) rst = 0;

        // directed corner vectors
        apply(32'h0005_0000, 20'h0, 1, 0, 0, 32'h0000_0FFF, 2'b00, 0);  // R2 limit 0FFFh
        apply(32'h0005_0000, 20'h0, 1, 0, 0, 32'h0000_1000, 2'b00, 0);  // R2 beyond
        apply(32'h0005_0000, 20'h0FC00, 0, 0, 1, 32'h0000_FFFE, 2'b01, 1); // R4 ok
        apply(32'h0005_0000, 20'h0FC00, 0, 0, 1, 32'h0000_FC00, 2'b01, 1); // R4 stack fault
        apply(32'h0, 20'hFFFFF, 1, 1, 1, 32'hFFFF_FFFF, 2'b00, 0);       // R4 empty
        apply(32'h0, 20'h0C000, 0, 0, 0, 32'h0000_BFFF, 2'b10, 0);       // R3 straddle

        // R9 idle cycle
        @(negedge clk) req_vld = 0; acc_off = 32'hFFFF_FFFF;
        @(posedge clk); #1;
        chk({61'd0, rsp_vld, rsp_gp_flt, rsp_stk_flt}, 64'd0, "R9 idle");

        // sweep
        for (int d = 0; d < 2; d++)
        for (int b = 0; b < 2; b++)
        for (int g = 0; g < 2; g++)
        for (int li = 0; li < 6; li++)
        for (int k = 0; k < 24; k++)
        for (int s = 0; s < 4; s++) begin
            logic [31:0] elim;
            elim = g ? {lims[li], 12'hFFF} : {12'd0, lims[li]};
            apply(32'hFFFF_F000 + 32'(k * 32'h123), lims[li], g[0], b[0], d[0],
                  pick_off(k, elim), 2'(s), (k % 2) == 1);
        end

        // reset while active: R10
        @(negedge clk) rst = 1;
        @(posedge clk); #1;
        chk({61'd0, rsp_vld, rsp_gp_flt, rsp_stk_flt}, 64'd0, "R10 reset again");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_vec++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule